// File: doc/BRIEF.md
# Line Data Double Bank with Data-Available Strobe

The block sits between a data-line decoder and a serial bus reader. The decoder writes bytes into a capture bank while a line is being received. When a line ends without a biphase error, the capture bank is copied as a whole into an output bank, and a new-data flag is set. A reader that is in the middle of a bus transaction never sees the output bank change under it. If the bus interface is addressed when the copy becomes due, the copy is held pending until the next bus START or STOP condition. While the copy is pending, the capture bank is frozen.

A completed read marks the data as consumed by clearing the new-data flag. From then on, the output presents all-ones until another good line has been copied. An active-low data-available output goes low once good data has arrived and returns high at the start of the next first field. At every data-line start the output is driven high for one cycle and then low for a programmable pulse length, so that a falling edge is always available for triggering. Reset is synchronous and active high.

Top module: `dline_bank`

## Requirements
- R1: During reset and on the first cycle after it, `out_data` is all ones, `new_flag` is 0 and `dav_n` is 1.
- R2: A cycle with `line_done`=1, `line_err`=0 and `bus_addr`=0 copies the capture bank into the output bank. On the next cycle `out_data` shows the copied bank and `new_flag` is 1.
- R3: A `line_done` cycle with `line_err`=1 starts no copy. `out_data` and `new_flag` are left unchanged by it.
- R4: A good `line_done` that arrives while `bus_addr`=1 leaves `out_data` and `new_flag` unchanged. The copy is made in the first cycle, from that one on, in which `bus_ss`=1, and its result shows on the following cycle.
- R5: From the cycle after a deferred copy became due until the cycle after it completes, writes to the capture bank are ignored.
- R6: `rd_done`=1 clears `new_flag` on the next cycle. While `new_flag` is 0, `out_data` is all ones. A copy in the same cycle as `rd_done` wins, and the flag stays set.
- R7: A new copy sets `new_flag` and replaces `out_data`, whether or not the previous data was read.
- R8: When no start pulse is running, `dav_n` goes low on the cycle after a copy and goes high on the cycle after `field_start`=1. If both happen in the same cycle, it goes low.
- R9: After a cycle with `line_start`=1, `dav_n` is 1 for one cycle and then 0 for `PULSE_CYC` cycles. After that it follows R8. A new `line_start` restarts this sequence.
- R10: A write with `wr_en`=1 and `wr_sel`=k (k < `NBYTES`) stores `wr_byte` in capture byte k, which appears at `out_data` bits [8k+7:8k] after a copy. A write with `wr_sel` >= `NBYTES` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Capture byte write strobe |
| wr_sel | input | SEL_W (3) | Capture byte index |
| wr_byte | input | BYTE_W (8) | Capture byte value |
| line_done | input | 1 | End of a data line |
| line_err | input | 1 | Biphase error seen on that line |
| line_start | input | 1 | Start of the data line |
| field_start | input | 1 | Start of a first field |
| bus_addr | input | 1 | Bus interface currently addressed |
| bus_ss | input | 1 | Bus START or STOP condition seen |
| rd_done | input | 1 | Reader finished reading the output bank |
| out_data | output | DATA_W (40) | Output bank, all ones when no new data |
| new_flag | output | 1 | Unread data present |
| dav_n | output | 1 | Active-low data available |

## Verification
The hardest situation to reach from the ports is a copy held pending across many cycles. In that window the capture bank must refuse writes, while reads, errored lines and repeated good lines also arrive. A directed sequence holds `bus_addr` high, issues a good line, writes a poisoned byte during the pending window, and only then raises `bus_ss`. It then confirms that the poisoned byte never reaches the output. The random phase toggles `bus_addr` as a slow level, so that pending windows of varied length overlap with reads, start pulses and field starts.

// File: rtl/dline_pkg.sv
package dline_pkg;

  typedef enum logic [1:0] {
    DAV_LEVEL = 2'd0,
    DAV_GUARD = 2'd1,
    DAV_LOW   = 2'd2
  } dav_phase_t;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dline_capture.sv
module dline_capture #(
  parameter int NBYTES = 5,
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              hold,
  output logic [DATA_W-1:0] cap_data
);

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic              hit;

    assign hit = wr_en && !hold && (wr_sel == SEL_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= '1;
      end else if (hit) begin
        byte_q <= wr_byte;
      end
    end

    assign cap_data[k*BYTE_W +: BYTE_W] = byte_q;
  end

endmodule

// File: rtl/dline_xfer.sv
module dline_xfer #(
  parameter int DATA_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_done,
  input  logic              line_err,
  input  logic              bus_addr,
  input  logic              bus_ss,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] out_data,
  output logic              new_flag,
  output logic              pend,
  output logic              fire
);

  logic              due;
  logic              pend_d;
  logic              flag_d;
  logic [DATA_W-1:0] bank_q;
  logic [DATA_W-1:0] bank_d;

  always_comb begin
    due    = line_done && !line_err;
    fire   = (due && !bus_addr) || ((pend || due) && bus_ss);
    pend_d = (pend || due) && !fire;
    bank_d = fire ? cap_data : bank_q;
    if (fire) begin
      flag_d = 1'b1;
    end else if (rd_done) begin
      flag_d = 1'b0;
    end else begin
      flag_d = new_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      new_flag <= 1'b0;
      bank_q   <= '1;
      out_data <= '1;
    end else begin
      pend     <= pend_d;
      new_flag <= flag_d;
      bank_q   <= bank_d;
      out_data <= flag_d ? bank_d : '1;
    end
  end

endmodule

// File: rtl/dline_dav.sv
module dline_dav
  import dline_pkg::*;
#(
  parameter int PULSE_CYC = 125,
  localparam int CNT_W = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic field_start,
  input  logic copy_set,
  output logic dav_n
);

  dav_phase_t       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;

  always_comb begin
    if (copy_set) begin
      valid_d = 1'b1;
    end else if (field_start) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end

    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (line_start) begin
      phase_d = DAV_GUARD;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        DAV_GUARD: begin
          phase_d = DAV_LOW;
          cnt_d   = CNT_W'(PULSE_CYC - 1);
        end
        DAV_LOW: begin
          if (cnt_q == '0) begin
            phase_d = DAV_LEVEL;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: phase_d = DAV_LEVEL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= DAV_LEVEL;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      dav_n   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      if (phase_d == DAV_GUARD) begin
        dav_n <= 1'b1;
      end else if (phase_d == DAV_LOW) begin
        dav_n <= 1'b0;
      end else begin
        dav_n <= !valid_d;
      end
    end
  end

endmodule

// File: rtl/dline_bank.sv
module dline_bank
  import dline_pkg::*;
#(
  parameter int NBYTES    = 5,
  parameter int BYTE_W    = 8,
  parameter int PULSE_CYC = 125,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int SEL_W  = sel_width(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              line_done,
  input  logic              line_err,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              bus_addr,
  input  logic              bus_ss,
  input  logic              rd_done,
  output logic [DATA_W-1:0] out_data,
  output logic              new_flag,
  output logic              dav_n
);

  logic [DATA_W-1:0] cap_data;
  logic              copy_pend;
  logic              copy_fire;

  dline_capture #(
    .NBYTES (NBYTES),
    .BYTE_W (BYTE_W),
    .SEL_W  (SEL_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_byte  (wr_byte),
    .hold     (copy_pend),
    .cap_data (cap_data)
  );

  dline_xfer #(
    .DATA_W (DATA_W)
  ) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .line_done (line_done),
    .line_err  (line_err),
    .bus_addr  (bus_addr),
    .bus_ss    (bus_ss),
    .rd_done   (rd_done),
    .cap_data  (cap_data),
    .out_data  (out_data),
    .new_flag  (new_flag),
    .pend      (copy_pend),
    .fire      (copy_fire)
  );

  dline_dav #(
    .PULSE_CYC (PULSE_CYC)
  ) u_dav (
    .clk         (clk),
    .rst         (rst),
    .line_start  (line_start),
    .field_start (field_start),
    .copy_set    (copy_fire),
    .dav_n       (dav_n)
  );

endmodule

// File: rtl/dline_bank_chk.sv
module dline_bank_chk #(
  parameter int DATA_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              line_done,
  input logic              line_err,
  input logic              line_start,
  input logic              bus_addr,
  input logic              bus_ss,
  input logic              rd_done,
  input logic [DATA_W-1:0] out_data,
  input logic              new_flag,
  input logic              dav_n
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (out_data == '1) && !new_flag && dav_n); // R1

  AST_FLAG_NEEDS_COPY: assert property (@(posedge clk) disable iff (rst)
    $rose(new_flag) |-> $past(bus_ss || (line_done && !line_err && !bus_addr))); // R2

  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (line_done && line_err && !bus_ss && !rd_done) |=> $stable(out_data) && $stable(new_flag)); // R3

  AST_ADDR_DEFERS: assert property (@(posedge clk) disable iff (rst)
    (line_done && !line_err && bus_addr && !bus_ss && !rd_done) |=> $stable(out_data) && $stable(new_flag)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !bus_ss && !(line_done && !line_err && !bus_addr)) |=> !new_flag); // R6

  AST_EMPTY_ONES: assert property (@(posedge clk) disable iff (rst)
    !new_flag |-> (out_data == '1)); // R6

  AST_PULSE_GUARD: assert property (@(posedge clk) disable iff (rst)
    line_start |=> dav_n); // R9

  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (rst)
    (line_start ##1 !line_start) |=> !dav_n); // R9

endmodule

bind dline_bank dline_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_done  (line_done),
  .line_err   (line_err),
  .line_start (line_start),
  .bus_addr   (bus_addr),
  .bus_ss     (bus_ss),
  .rd_done    (rd_done),
  .out_data   (out_data),
  .new_flag   (new_flag),
  .dav_n      (dav_n)
);

// File: tb/dline_bank_bench.sv
`timescale 1ns/1ps
module dline_bank_bench;

  localparam int NB     = 5;
  localparam int BW     = 8;
  localparam int PC     = 6;
  localparam int DW     = NB * BW;
  localparam int SW     = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, line_done = 0, line_err = 0, line_start = 0;
  logic field_start = 0, bus_addr = 0, bus_ss = 0, rd_done = 0;
  logic [SW-1:0] wr_sel = '0;
  logic [BW-1:0] wr_byte = '0;
  logic [DW-1:0] out_data;
  logic new_flag, dav_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dline_bank #(.NBYTES(NB), .BYTE_W(BW), .PULSE_CYC(PC)) u_dline_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .line_done(line_done), .line_err(line_err), .line_start(line_start),
    .field_start(field_start), .bus_addr(bus_addr), .bus_ss(bus_ss),
    .rd_done(rd_done), .out_data(out_data), .new_flag(new_flag), .dav_n(dav_n)
  );

  // reference model built from the requirements
  logic [DW-1:0] m_cap, m_bank;
  bit m_flag, m_pend, m_valid;
  int m_phase, m_cnt;

  function automatic bit exp_dav();
    if (m_phase == 1) return 1'b1;
    if (m_phase == 2) return 1'b0;
    return !m_valid;
  endfunction

  function automatic logic [DW-1:0] exp_out();
    return m_flag ? m_bank : '1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cap = '1; m_bank = '1; m_flag = 0; m_pend = 0; m_valid = 0;
      m_phase = 0; m_cnt = 0;
    end else begin
      bit due, fire;
      due  = line_done && !line_err;
      fire = (due && !bus_addr) || ((m_pend || due) && bus_ss);
      if (fire) m_bank = m_cap;
      if (wr_en && !m_pend && wr_sel < NB) m_cap[wr_sel*BW +: BW] = wr_byte;
      m_pend = (m_pend || due) && !fire;
      if (fire) m_flag = 1; else if (rd_done) m_flag = 0;
      if (fire) m_valid = 1; else if (field_start) m_valid = 0;
      if (line_start) begin m_phase = 1; m_cnt = 0; end
      else if (m_phase == 1) begin m_phase = 2; m_cnt = PC - 1; end
      else if (m_phase == 2) begin
        if (m_cnt == 0) m_phase = 0; else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic chk(input string tag);
    checks++;
    if (out_data !== exp_out() || new_flag !== m_flag || dav_n !== exp_dav()) begin
      fails++;
      $display("FAIL %s: out=%h flag=%b dav_n=%b expected out=%h flag=%b dav_n=%b",
               tag, out_data, new_flag, dav_n, exp_out(), m_flag, exp_dav());
    end
  endtask

  task automatic chk_data(input string tag, input logic [DW-1:0] exp);
    checks++;
    if (out_data !== exp) begin
      fails++;
      $display("FAIL %s: out=%h expected %h", tag, out_data, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag);
    wr_en = 0; line_done = 0; line_err = 0; line_start = 0;
    field_start = 0; bus_ss = 0; rd_done = 0;
  endtask

  task automatic wr(input int sel, input logic [7:0] b, input string tag);
    wr_en = 1; wr_sel = SW'(sel); wr_byte = b;
    step(tag);
  endtask

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    step("R1");

    for (int k = 0; k < NB; k++) wr(k, 8'h10 + 8'(k), "R10");
    wr(5, 8'h00, "R10");
    wr(7, 8'h00, "R10");
    line_done = 1; step("R2");
    chk_data("R10", 40'h1413121110);
    step("R2");

    rd_done = 1; step("R6");
    chk_data("R6", '1);
    step("R6");

    wr(0, 8'h21, "R3");
    line_done = 1; line_err = 1; step("R3");
    step("R3");

    bus_addr = 1;
    line_done = 1; step("R4");
    wr(2, 8'hAA, "R5");
    step("R4"); step("R4");
    bus_ss = 1; step("R4");
    chk_data("R5", 40'h1413121121);
    bus_addr = 0;
    wr(2, 8'h77, "R5");

    wr(1, 8'h55, "R7");
    line_done = 1; step("R7");
    chk_data("R7", 40'h1413775521);
    line_done = 1; rd_done = 1; step("R6");

    field_start = 1; step("R8");
    line_done = 1; step("R8");
    field_start = 1; line_done = 1; step("R8");
    field_start = 1; step("R8");

    line_start = 1; step("R9");
    for (int i = 0; i < PC + 3; i++) step("R9");
    line_done = 1; step("R9");
    line_start = 1; step("R9");
    step("R9");
    line_start = 1; step("R9");
    for (int i = 0; i < PC + 3; i++) step("R9");

    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 5000; n++) begin
      wr_en       = ($urandom % 3) == 0;
      wr_sel      = SW'($urandom % 8);
      wr_byte     = 8'($urandom);
      line_done   = ($urandom % 20) == 0;
      line_err    = ($urandom % 3) == 0;
      if (($urandom % 30) == 0) bus_addr = !bus_addr;
      bus_ss      = ($urandom % 15) == 0;
      rd_done     = ($urandom % 25) == 0;
      line_start  = ($urandom % 40) == 0;
      field_start = ($urandom % 40) == 0;
      step("random R2 R4 R5 R6 R7 R8 R9");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule